// File: doc/BRIEF.md
# Registered Eight-Function 16-bit ALU

This block is a 16-bit arithmetic logic unit whose two operands and whose result are all held in edge-triggered registers. On every rising clock edge the operand registers capture the words presented on the operand inputs. At that same edge, the result register loads the outcome of the function that the 3-bit select picks, computed from the operands captured one edge earlier. A one-bit carry flag is registered at the same edge as the result, so the two always describe the same operation.

There are eight functions: add with carry-in, two's-complement subtract, a variable left shift of 1 to 4 places, bitwise AND, bitwise OR, pass-through of the first operand, an 8x8 unsigned multiply giving a 16-bit product, and a hold code. The hold code makes the result register reload its own contents. Surrounding logic treats the block as a two-stage pipe: operands go in at one edge, and the result is visible after the next one.

Top module: `alu16_reg`

## Requirements
- R1: The operand registers load `a_in` and `b_in` at every rising edge. The result written at an edge is computed from the operands loaded at the previous edge, together with `op_sel` and `carry_in` as sampled at that edge.
- R2: Select 3'b000 (add) writes A + B + `carry_in` modulo 2^16 to the result. The carry flag receives bit 16 of that sum.
- R3: Select 3'b001 (subtract) writes A + ~B + 1 (A minus B, modulo 2^16) to the result. The carry flag receives bit 16 of that sum, so it is 1 exactly when A >= B as unsigned numbers.
- R4: Select 3'b010 (shift) writes A shifted left by B[1:0]+1 places. Codes 0..3 give shifts of 1..4, zeros fill the vacated low bits, and B[15:2] has no effect.
- R5: Select 3'b011 writes A AND B, and select 3'b100 writes A OR B.
- R6: Select 3'b101 writes A unchanged.
- R7: Select 3'b110 writes the unsigned product A[7:0] * B[7:0] as a full 16-bit value. A[15:8] and B[15:8] have no effect.
- R8: Select 3'b111 (hold) leaves the result register unchanged at that edge.
- R9: The carry flag is written as 0 at any edge whose select is neither add nor subtract.
- R10: While `rst` is high at a rising edge (synchronous, active high), the edge clears the operand registers, the result and the carry flag to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | First operand, loaded into register A |
| b_in | input | 16 | Second operand, loaded into register B |
| op_sel | input | 3 | Function select |
| carry_in | input | 1 | Carry into the add function |
| result | output | 16 | Registered result |
| carry_out | output | 1 | Registered carry flag |

## Verification
The bench drives every shift code over a spread of operand words. A design that decodes the amount as B[1:0] rather than B[1:0]+1, or that lets high bits of B take part, misses the top bits or the zero fill. The multiply sweep puts changing garbage in the upper operand bytes, so a design that feeds full words into the product shows it immediately. The add and subtract cases sit on the carry boundaries: all ones plus carry-in, equal operands, and A one below B. These catch an inverted or misplaced carry and a subtract that forgets the +1. The hold follows an add that produced a carry, with fresh operands applied, which exposes a design that recomputes the result or leaves a stale carry flag behind. A step in which the operand input changes between two edges confirms the one-edge operand latency.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int unsigned WORD_W   = 16;
    localparam int unsigned SHAMT_W  = 2;
    localparam int unsigned OP_W     = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_SHL  = 3'b010,
        OP_AND  = 3'b011,
        OP_OR   = 3'b100,
        OP_PASS = 3'b101,
        OP_MUL  = 3'b110,
        OP_HOLD = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic from_add;
        logic from_sub;
        logic hold;
    } op_ctrl_t;

    function automatic op_ctrl_t decode_op(input alu_op_e op);
        op_ctrl_t c;
        c.from_add = (op == OP_ADD);
        c.from_sub = (op == OP_SUB);
        c.hold     = (op == OP_HOLD);
        return c;
    endfunction

endpackage

// File: rtl/alu16_word_reg.sv
module alu16_word_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/alu16_barrel_shl.sv
module alu16_barrel_shl #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SHAMT_W = 2
) (
    input  logic [DATA_W-1:0]  din,
    input  logic [SHAMT_W-1:0] code,
    output logic [DATA_W-1:0]  dout
);
    localparam int unsigned NSTG = SHAMT_W + 1;

    logic [NSTG-1:0]   amount;
    logic [DATA_W-1:0] stg [0:NSTG];

    assign amount = {1'b0, code} + NSTG'(1);
    assign stg[0] = din;

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        assign stg[s+1] = amount[s] ? (stg[s] << (1 << s)) : stg[s];
    end

    assign dout = stg[NSTG];
endmodule

// File: rtl/alu16_func_unit.sv
module alu16_func_unit #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SHAMT_W = 2
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              sum_c,
    output logic [DATA_W-1:0] diff,
    output logic              diff_c,
    output logic [DATA_W-1:0] shl,
    output logic [DATA_W-1:0] conj,
    output logic [DATA_W-1:0] disj,
    output logic [DATA_W-1:0] prod
);
    localparam int unsigned HALF = DATA_W / 2;

    logic [DATA_W:0] add_full;
    logic [DATA_W:0] sub_full;

    assign add_full = {1'b0, a} + {1'b0, b} + (DATA_W+1)'(cin);
    assign sub_full = {1'b0, a} + {1'b0, ~b} + (DATA_W+1)'(1);

    assign sum    = add_full[DATA_W-1:0];
    assign sum_c  = add_full[DATA_W];
    assign diff   = sub_full[DATA_W-1:0];
    assign diff_c = sub_full[DATA_W];

    assign conj = a & b;
    assign disj = a | b;
    assign prod = DATA_W'(a[HALF-1:0] * b[HALF-1:0]);

    alu16_barrel_shl #(
        .DATA_W  (DATA_W),
        .SHAMT_W (SHAMT_W)
    ) u_shl (
        .din  (a),
        .code (b[SHAMT_W-1:0]),
        .dout (shl)
    );
endmodule

// File: rtl/alu16_result_sel.sv
module alu16_result_sel
    import alu16_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] sum,
    input  logic              sum_c,
    input  logic [DATA_W-1:0] diff,
    input  logic              diff_c,
    input  logic [DATA_W-1:0] shl,
    input  logic [DATA_W-1:0] conj,
    input  logic [DATA_W-1:0] disj,
    input  logic [DATA_W-1:0] pass,
    input  logic [DATA_W-1:0] prod,
    input  logic [DATA_W-1:0] fb,
    output logic [DATA_W-1:0] nxt,
    output logic              nxt_c
);
    op_ctrl_t ctrl;
    assign ctrl = decode_op(op);

    always_comb begin
        unique case (op)
            OP_ADD:  nxt = sum;
            OP_SUB:  nxt = diff;
            OP_SHL:  nxt = shl;
            OP_AND:  nxt = conj;
            OP_OR:   nxt = disj;
            OP_PASS: nxt = pass;
            OP_MUL:  nxt = prod;
            default: nxt = fb;
        endcase
    end

    always_comb begin
        nxt_c = 1'b0;
        if (ctrl.from_add) nxt_c = sum_c;
        if (ctrl.from_sub) nxt_c = diff_c;
    end
endmodule

// File: rtl/alu16_reg.sv
module alu16_reg
    import alu16_pkg::*;
#(
    parameter int unsigned DATA_W  = WORD_W,
    parameter int unsigned SHAMT_W = alu16_pkg::SHAMT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [OP_W-1:0]   op_sel,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);
    localparam int unsigned RES_W = DATA_W + 1;

    logic [DATA_W-1:0] a_q, b_q;
    logic [DATA_W-1:0] sum, diff, shl, conj, disj, prod;
    logic              sum_c, diff_c;
    logic [DATA_W-1:0] nxt;
    logic              nxt_c;
    logic [RES_W-1:0]  res_q;

    alu16_word_reg #(.W(DATA_W)) u_areg (
        .clk (clk), .rst (rst), .d (a_in), .q (a_q)
    );
    alu16_word_reg #(.W(DATA_W)) u_breg (
        .clk (clk), .rst (rst), .d (b_in), .q (b_q)
    );

    alu16_func_unit #(
        .DATA_W  (DATA_W),
        .SHAMT_W (SHAMT_W)
    ) u_fu (
        .a      (a_q),
        .b      (b_q),
        .cin    (carry_in),
        .sum    (sum),
        .sum_c  (sum_c),
        .diff   (diff),
        .diff_c (diff_c),
        .shl    (shl),
        .conj   (conj),
        .disj   (disj),
        .prod   (prod)
    );

    alu16_result_sel #(.DATA_W(DATA_W)) u_sel (
        .op     (alu_op_e'(op_sel)),
        .sum    (sum),
        .sum_c  (sum_c),
        .diff   (diff),
        .diff_c (diff_c),
        .shl    (shl),
        .conj   (conj),
        .disj   (disj),
        .pass   (a_q),
        .prod   (prod),
        .fb     (result),
        .nxt    (nxt),
        .nxt_c  (nxt_c)
    );

    alu16_word_reg #(.W(RES_W)) u_rreg (
        .clk (clk), .rst (rst), .d ({nxt_c, nxt}), .q (res_q)
    );

    assign result    = res_q[DATA_W-1:0];
    assign carry_out = res_q[DATA_W];
endmodule

// File: rtl/alu16_reg_chk.sv
module alu16_reg_chk
    import alu16_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] a_in,
    input logic [OP_W-1:0]   op_sel,
    input logic [DATA_W-1:0] a_q,
    input logic [DATA_W-1:0] result,
    input logic              carry_out
);
    assert_operand_load_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (a_q == $past(a_in)));

    assert_pass_R6: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_PASS) |=> (result == $past(a_q)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_HOLD) |=> $stable(result));

    assert_carry_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (op_sel != OP_ADD && op_sel != OP_SUB) |=> !carry_out);

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (result == '0 && !carry_out && a_q == '0));
endmodule

bind alu16_reg alu16_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_in      (a_in),
    .op_sel    (op_sel),
    .a_q       (a_q),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/tb_alu16_reg.sv
`timescale 1ns/1ps
module tb_alu16_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_in = '0, b_in = '0;
    logic [2:0]  op_sel = 3'b000;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    alu16_reg dut (
        .clk (clk), .rst (rst), .a_in (a_in), .b_in (b_in),
        .op_sel (op_sel), .carry_in (carry_in),
        .result (result), .carry_out (carry_out)
    );

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic [2:0] op, input logic cin);
        @(negedge clk);
        a_in = a; b_in = b; op_sel = op; carry_in = cin;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [16:0] exp;
        logic [15:0] a, b;
        // R10: reset clears everything, operand A observed through pass
        a_in = 16'hFFFF; op_sel = 3'b101;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 result after reset", {carry_out, result}, 17'h0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R10 operand A cleared", {carry_out, result}, 17'h0);
        // R1: one-edge operand latency
        a_in = 16'h1234;
        @(posedge clk); @(negedge clk);
        a_in = 16'h4321;
        @(posedge clk); @(negedge clk);
        check("R1 latency", {carry_out, result}, {1'b0, 16'h1234});
        check("R6 pass", {carry_out, result}, {1'b0, 16'h1234});

        // R2 add boundaries
        apply(16'hFFFF, 16'h0001, 3'b000, 1'b0);
        check("R2 add wrap", {carry_out, result}, {1'b1, 16'h0000});
        apply(16'hFFFF, 16'h0000, 3'b000, 1'b1);
        check("R2 add cin wrap", {carry_out, result}, {1'b1, 16'h0000});
        apply(16'hFFFF, 16'hFFFF, 3'b000, 1'b1);
        check("R2 add max", {carry_out, result}, {1'b1, 16'hFFFF});
        apply(16'h000A, 16'h0002, 3'b000, 1'b1);
        check("R2 add small", {carry_out, result}, {1'b0, 16'h000D});

        // R3 subtract
        apply(16'h0007, 16'h0007, 3'b001, 1'b0);
        check("R3 sub equal", {carry_out, result}, {1'b1, 16'h0000});
        apply(16'h0006, 16'h0007, 3'b001, 1'b1);
        check("R3 sub below", {carry_out, result}, {1'b0, 16'hFFFF});
        apply(16'h8000, 16'h0001, 3'b001, 1'b0);
        check("R3 sub above", {carry_out, result}, {1'b1, 16'h7FFF});

        // R4 shift sweep, junk in B upper bits
        for (int i = 0; i < 24; i++) begin
            for (int s = 0; s < 4; s++) begin
                a = 16'(i * 16'h0A4F) ^ 16'hFBFF;
                b = {14'(i * 16'h0133), 2'(s)};
                apply(a, b, 3'b010, 1'b1);
                exp = {1'b0, 16'(a << (s + 1))};
                check("R4 shift", {carry_out, result}, exp);
            end
        end

        // R5 and R9 logic ops
        apply(16'hA5F0, 16'h0FF3, 3'b011, 1'b1);
        check("R5 and / R9", {carry_out, result}, {1'b0, 16'h05F0});
        apply(16'h1010, 16'h0101, 3'b100, 1'b1);
        check("R5 or / R9", {carry_out, result}, {1'b0, 16'h1111});

        // R7 multiply sweep with changing upper bytes
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                a = {8'(x * 37 + y), 8'(x * 17)};
                b = {8'(y * 91 + 3), 8'(255 - y * 16)};
                apply(a, b, 3'b110, 1'b1);
                exp = {1'b0, 16'(a[7:0] * b[7:0])};
                check("R7 multiply", {carry_out, result}, exp);
            end
        end

        // R8 hold after a carrying add, new operands presented
        apply(16'h8000, 16'h8001, 3'b000, 1'b0);
        check("R2 add before hold", {carry_out, result}, {1'b1, 16'h0001});
        apply(16'hBEEF, 16'hCAFE, 3'b111, 1'b1);
        check("R8 hold / R9 carry", {carry_out, result}, {1'b0, 16'h0001});
        apply(16'h0F0F, 16'h3333, 3'b111, 1'b0);
        check("R8 hold again", {carry_out, result}, {1'b0, 16'h0001});

        done = 1;
    end

    initial begin
        for (int n = 0; n < 100000 && !done; n++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule